// File: doc/BRIEF.md
# Inter-processor message register block

This block gives the cores of a multi-core chip a simple mailbox for signalling one another. It holds a small bank of 32-bit message slots and one shared enable register on a single-cycle register bus. A core posts a word into a slot. If that slot is enabled and is allowed to interrupt, the slot's interrupt line rises. The receiving core reads the slot, which returns the word and drops the interrupt in the same access. No separate acknowledge is needed.

Each slot has its own word address. The enable register can be reached at a fixed distance above every slot address, and all of these aliases reach the same register. Software changes single enable bits by read-modify-write.

A build-time receive mask decides which slots may raise an interrupt at all. A slot outside the mask still stores and returns data but keeps its interrupt low. The bus carries whole 32-bit words, with bit 31 as the most significant bit. The slot count, data width, address width, slot spacing, enable offset and receive mask are all parameters.

Top module: `ipmsg_block`

## Requirements
- R1: After reset every slot holds zero, the enable register is zero, every interrupt line is low and the read data output is zero.
- R2: Slot i sits at byte offset i*0x10. The enable register is reached at offset 0x100 + i*0x10 for every i, and all of these aliases reach one register. Bit i of the enable register enables slot i. A write to the enable register replaces all four enable bits with data bits 3:0. A read returns them in bits 3:0, with the other bits zero.
- R3: A write to a slot stores the full 32-bit word whatever the state of the enable bit.
- R4: A write to an enabled slot whose receive-mask bit is set drives that slot's interrupt high from the clock edge that takes the write.
- R5: A read of a slot places the stored word on the read data output in the cycle after the strobe. The same edge that takes the read clears the slot's interrupt.
- R6: A write to a slot whose enable bit is clear does not raise its interrupt.
- R7: The receive mask (default 0xF) selects which slots can interrupt. A slot whose mask bit is clear never drives its interrupt, even when it is enabled and written.
- R8: When a read and an enabled write hit the same slot in the same cycle, the write wins. The interrupt stays high, the new word is stored, and the read returns the old word.
- R9: Reads of unmapped offsets return zero. Writes to unmapped offsets change no slot, no enable bit and no interrupt.
- R10: A raised interrupt stays high until its slot is read. Clearing the enable bit does not drop it, and setting an enable bit later does not raise an interrupt for a word written while the slot was disabled.
- R11: An access to one slot leaves the data and interrupt state of every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data word |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe, zero otherwise |
| irq | output | 4 | One interrupt line per slot |

## Verification
The messaging path is tried with the enable bit set and with it clear. It is also tried with the enable bit toggled after a post, which tells a pending flag taken at write time apart from one gated by the current enable. Distinct data patterns go to different slots, so that a wrong decode or a leak between neighbouring slots shows up in the read data or on the interrupt lines. A second instance with a sparse receive mask shares the same bus, so the masked and unmasked behaviour can be compared under identical traffic. A read and a write to the same slot in one cycle, and accesses to unmapped holes, cover the collision and decode corners.

// File: rtl/ipmsg_pkg.sv
package ipmsg_pkg;

   localparam int unsigned WORD_BYTES = 4;

   // byte offset of slot idx inside a window whose slots are stride apart
   function automatic int unsigned slot_offset(input int unsigned idx,
                                               input int unsigned stride);
      return idx * stride;
   endfunction

endpackage

// File: rtl/ipmsg_decode.sv
module ipmsg_decode #(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned STRIDE    = 16,
   parameter int unsigned EN_OFS    = 256
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_SLOTS-1:0] slot_sel,
   output logic                 en_sel
);
   import ipmsg_pkg::*;

   logic [NUM_SLOTS-1:0] en_alias;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_dec
      localparam int unsigned SLOT_OFS  = slot_offset(i, STRIDE);
      localparam int unsigned ALIAS_OFS = EN_OFS + slot_offset(i, STRIDE);
      assign slot_sel[i] = (addr == ADDR_W'(SLOT_OFS));
      assign en_alias[i] = (addr == ADDR_W'(ALIAS_OFS));
   end

   assign en_sel = |en_alias;

   // R2
   one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({slot_sel, en_sel}));

endmodule

// File: rtl/ipmsg_enable.sv
module ipmsg_enable #(
   parameter int unsigned NUM_SLOTS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_hit,
   input  logic [NUM_SLOTS-1:0] wdata,
   output logic [NUM_SLOTS-1:0] en_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= '0;
      else if (wr_hit) en_q <= wdata;
   end

   // R2
   en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (en_q == $past(wdata)));

   // R9
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(en_q));

endmodule

// File: rtl/ipmsg_slot.sv
module ipmsg_slot #(
   parameter int unsigned DATA_W = 32,
   parameter bit          CAN_RX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic              rd_hit,
   input  logic              enable,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] msg,
   output logic              pend
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      msg <= '0;
      else if (wr_hit) msg <= wdata;
   end

   // R3
   store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (msg == $past(wdata)));

   // R11
   msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(msg));

   if (CAN_RX) begin : g_rx
      logic post;
      assign post = wr_hit & enable;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pend <= 1'b0;
         else if (post)   pend <= 1'b1;
         else if (rd_hit) pend <= 1'b0;
      end

      // R4
      pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit && enable) |=> pend);

      // R5
      rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_hit && !(wr_hit && enable)) |=> !pend);

      // R6
      quiet_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit && !enable && !pend) |=> !pend);

      // R10
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pend && !rd_hit) |=> pend);
   end else begin : g_norx
      assign pend = 1'b0;
   end

endmodule

// File: rtl/ipmsg_block.sv
module ipmsg_block #(
   parameter int unsigned NUM_SLOTS = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned STRIDE    = 16,
   parameter int unsigned EN_OFS    = 256,
   parameter logic [3:0]  RX_MASK   = 4'hF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [NUM_SLOTS-1:0] irq
);
   import ipmsg_pkg::*;

   localparam int unsigned SPAN     = NUM_SLOTS * STRIDE;
   localparam int unsigned TOP_BYTE = EN_OFS + SPAN;

   if (NUM_SLOTS != 4) begin : g_bad_count
      $error("ipmsg_block: NUM_SLOTS must be 4 to match the receive mask");
   end
   if (STRIDE % WORD_BYTES != 0 || STRIDE == 0) begin : g_bad_stride
      $error("ipmsg_block: STRIDE must be a nonzero multiple of the word size");
   end
   if (EN_OFS < SPAN || EN_OFS % WORD_BYTES != 0) begin : g_bad_enofs
      $error("ipmsg_block: enable aliases overlap the slots");
   end
   if (TOP_BYTE > (1 << ADDR_W)) begin : g_bad_addr
      $error("ipmsg_block: ADDR_W too narrow for the map");
   end
   if (DATA_W < NUM_SLOTS) begin : g_bad_data
      $error("ipmsg_block: DATA_W narrower than the enable field");
   end

   logic [NUM_SLOTS-1:0] slot_sel;
   logic                 en_sel;
   logic [NUM_SLOTS-1:0] en_q;
   logic [NUM_SLOTS-1:0] pend;
   logic [DATA_W-1:0]    msg_arr [NUM_SLOTS];
   logic [DATA_W-1:0]    rd_next;

   ipmsg_decode #(
      .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W),
      .STRIDE(STRIDE), .EN_OFS(EN_OFS)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr),
      .slot_sel(slot_sel), .en_sel(en_sel)
   );

   ipmsg_enable #(.NUM_SLOTS(NUM_SLOTS)) u_en (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(bus_wr & en_sel),
      .wdata(bus_wdata[NUM_SLOTS-1:0]),
      .en_q(en_q)
   );

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      ipmsg_slot #(.DATA_W(DATA_W), .CAN_RX(RX_MASK[i])) u_slot (
         .clk(clk), .rst_n(rst_n),
         .wr_hit(bus_wr & slot_sel[i]),
         .rd_hit(bus_rd & slot_sel[i]),
         .enable(en_q[i]),
         .wdata(bus_wdata),
         .msg(msg_arr[i]),
         .pend(pend[i])
      );
   end

   always_comb begin
      rd_next = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (slot_sel[i]) rd_next = rd_next | msg_arr[i];
      end
      if (en_sel) rd_next = DATA_W'(en_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_next;
      else             bus_rdata <= '0;
   end

   assign irq = pend;

   // R5
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0));

   // R9
   hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !(|slot_sel) && !en_sel) |=> (bus_rdata == '0));

endmodule

// File: tb/ipmsg_block_test.sv
module ipmsg_block_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, rdata_m;
   logic [3:0]  irq, irq_m;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipmsg_block uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
   );

   ipmsg_block #(.RX_MASK(4'b0101)) uut_m (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
      .bus_wdata(wdata), .bus_rdata(rdata_m), .irq(irq_m)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; rd = 1'b1;
      @(negedge clk); rd = 1'b0; d = rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 irq", 32'(irq), 0);
      check("R1 rdata", rdata, 0);
      for (int i = 0; i < 4; i++) begin
         bus_read(12'(i*16), v);
         check("R1 slot", v, 0);
      end
      bus_read(12'h100, v);
      check("R1 enable", v, 0);
   endtask

   task automatic t_map();
      logic [31:0] v;
      bus_write(12'h110, 32'h5);
      bus_read(12'h130, v);
      check("R2 alias", v, 32'h5);
      bus_write(12'h120, 32'hFFFF_FFF0);
      bus_read(12'h100, v);
      check("R2 field", v, 0);
      bus_write(12'h000, 32'h0000_0001);
      bus_write(12'h010, 32'h0000_0002);
      bus_write(12'h020, 32'h0000_0004);
      bus_write(12'h030, 32'h0000_0008);
      for (int i = 0; i < 4; i++) begin
         bus_read(12'(i*16), v);
         check("R2 slot map", v, 32'(1 << i));
      end
   endtask

   task automatic t_disabled_write();
      logic [31:0] v;
      bus_write(12'h100, 32'h0);
      bus_write(12'h010, 32'hA5A5_1234);
      check("R6 no irq", 32'(irq), 0);
      bus_read(12'h010, v);
      check("R3 stored", v, 32'hA5A5_1234);
   endtask

   task automatic t_enabled_write();
      logic [31:0] v;
      bus_read(12'h100, v);
      bus_write(12'h100, v | 32'h4);
      bus_write(12'h020, 32'hDEAD_BEEF);
      check("R4 irq", 32'(irq), 32'h4);
      bus_read(12'h010, v);
      check("R11 neighbour", v, 32'hA5A5_1234);
      check("R11 irq kept", 32'(irq), 32'h4);
      bus_read(12'h020, v);
      check("R5 data", v, 32'hDEAD_BEEF);
      check("R5 cleared", 32'(irq), 0);
   endtask

   task automatic t_disable_one();
      logic [31:0] v;
      bus_write(12'h100, 32'hF);
      bus_read(12'h100, v);
      bus_write(12'h100, v & ~32'h2);
      bus_read(12'h120, v);
      check("R2 rmw", v, 32'hD);
      bus_write(12'h010, 32'h1111_0000);
      check("R6 disabled slot", 32'(irq), 0);
      bus_write(12'h030, 32'h3333_0000);
      check("R4 slot3", 32'(irq), 32'h8);
      bus_read(12'h030, v);
      check("R5 slot3 clear", 32'(irq), 0);
   endtask

   task automatic t_sticky();
      logic [31:0] v;
      bus_write(12'h100, 32'h1);
      bus_write(12'h000, 32'hCAFE_0001);
      bus_write(12'h100, 32'h0);
      check("R10 held", 32'(irq), 32'h1);
      bus_read(12'h000, v);
      check("R10 read clears", 32'(irq), 0);
      bus_write(12'h000, 32'hCAFE_0002);
      bus_write(12'h100, 32'h1);
      check("R10 late enable", 32'(irq), 0);
   endtask

   task automatic t_collision();
      logic [31:0] v;
      bus_write(12'h100, 32'h1);
      bus_write(12'h000, 32'h0000_0011);
      @(negedge clk); addr = 12'h000; wdata = 32'h0000_0022; wr = 1'b1; rd = 1'b1;
      @(negedge clk); wr = 1'b0; rd = 1'b0;
      check("R8 old data", rdata, 32'h11);
      check("R8 irq stays", 32'(irq), 32'h1);
      bus_read(12'h000, v);
      check("R8 new data", v, 32'h22);
      check("R8 cleared", 32'(irq), 0);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      bus_write(12'h100, 32'h0);
      bus_write(12'h104, 32'hF);
      bus_write(12'h008, 32'h7777_7777);
      bus_write(12'h040, 32'h8888_8888);
      bus_write(12'h200, 32'hF);
      bus_read(12'h100, v);
      check("R9 enable kept", v, 0);
      bus_read(12'h000, v);
      check("R9 slot0 kept", v, 32'h22);
      bus_read(12'h040, v);
      check("R9 hole read", v, 0);
      bus_read(12'h008, v);
      check("R9 misaligned read", v, 0);
      check("R9 irq", 32'(irq), 0);
   endtask

   task automatic t_mask();
      logic [31:0] v;
      bus_write(12'h100, 32'hF);
      for (int i = 0; i < 4; i++) bus_write(12'(i*16), 32'(32'h100 + i));
      check("R7 full mask", 32'(irq), 32'hF);
      check("R7 sparse mask", 32'(irq_m), 32'h5);
      @(negedge clk); addr = 12'h010; rd = 1'b1;
      @(negedge clk); rd = 1'b0;
      check("R7 masked data", rdata_m, 32'h101);
      for (int i = 0; i < 4; i++) bus_read(12'(i*16), v);
      check("R7 cleared", 32'(irq | irq_m), 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_map();
      t_disabled_write();
      t_enabled_write();
      t_disable_one();
      t_sticky();
      t_collision();
      t_unmapped();
      t_mask();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule